// File: doc/BRIEF.md
# Packed Logical Left Shifter

This block shifts a 64-bit operand left, either as two independent 32-bit lanes or as one 64-bit lane, and fills the vacated low-order bits with zeros. The lane size and the origin of the shift amount both come from an opcode byte. Two opcodes take the amount from a second 64-bit operand. Two others take it from an 8-bit immediate, and for those a 3-bit selector field from the instruction's addressing byte must hold the value 110b.

The unit sits in an execution pipeline as a single-stage slice. Each cycle, with `in_valid` asserted, it accepts one operation. Exactly one clock edge later it presents either a shifted result with `out_valid` or an `out_illegal` pulse for an encoding it does not recognise. It does not fetch operands from memory, and it has no right or arithmetic shifts.

Top module: `packed_lsh`

## Requirements
- R1: Opcode F2h shifts each 32-bit lane (bits 31:0 and 63:32) left by the value on `in_count`; `in_imm` and `in_reg_field` are ignored.
- R2: Opcode F3h shifts the whole 64-bit word left by the value on `in_count`; `in_imm` and `in_reg_field` are ignored.
- R3: Opcodes 72h (32-bit lanes) and 73h (64-bit lane) with `in_reg_field` = 110b take the shift amount from `in_imm`, zero-extended; `in_count` is ignored.
- R4: The shift amount is an unsigned number of its full width, and any amount greater than or equal to the lane width (32 or 64) clears the lane entirely, including amounts whose low bits alone would be small.
- R5: Vacated low-order bits are filled with zeros, bits shifted past a lane's top are discarded and never enter the neighbouring lane, and an amount of zero passes the lane unchanged.
- R6: A valid operation with opcode 72h or 73h and any `in_reg_field` other than 110b, or with any opcode other than F2h, F3h, 72h and 73h, raises `out_illegal` for one cycle with `out_valid` low and leaves `result` unchanged.
- R7: `out_valid` and `result` appear one clock edge after the operation is presented, and a new operation is accepted every cycle.
- R8: A cycle with `in_valid` low produces neither `out_valid` nor `out_illegal` on the following cycle and leaves `result` unchanged.
- R9: While `rst_n` is low, `out_valid` and `out_illegal` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_opcode | input | 8 | Opcode byte selecting lane size and amount source |
| in_reg_field | input | 3 | Selector field, must be 110b for the immediate forms |
| in_data | input | 64 | Operand to shift |
| in_count | input | 64 | Shift amount for the operand-count forms |
| in_imm | input | 8 | Shift amount for the immediate forms |
| out_valid | output | 1 | Result is valid this cycle |
| out_illegal | output | 1 | Operation in the previous cycle had an unsupported encoding |
| result | output | 64 | Shifted value, held until the next legal operation |

## Verification
Each of the three outputs is due exactly one rising edge after the operation is presented. The bench therefore drives inputs on a falling edge and checks the previous operation's outputs at the next falling edge, just before it drives the following operation. This keeps the input stream back to back, so full throughput is covered on every cycle of the sweep. Illegal and idle cycles are checked against the last legal result, which the bench tracks itself.

// File: rtl/lsh_pkg.sv
package lsh_pkg;

   // Opcode encodings; the decoder relies on these values
   localparam logic [7:0] OPC_NARROW_VAR = 8'hF2;
   localparam logic [7:0] OPC_WIDE_VAR   = 8'hF3;
   localparam logic [7:0] OPC_NARROW_IMM = 8'h72;
   localparam logic [7:0] OPC_WIDE_IMM   = 8'h73;
   localparam logic [2:0] IMM_REG_SEL    = 3'b110;

   typedef enum logic {
      LANE_NARROW = 1'b0,
      LANE_WIDE   = 1'b1
   } lane_sel_e;

   typedef enum logic {
      CNT_FROM_OPERAND = 1'b0,
      CNT_FROM_IMM     = 1'b1
   } cnt_src_e;

   typedef struct packed {
      logic      legal;
      lane_sel_e lane;
      cnt_src_e  src;
   } op_decode_t;

endpackage

// File: rtl/lsh_decode.sv
module lsh_decode
   import lsh_pkg::*;
#(
   parameter logic [7:0] NARROW_VAR = OPC_NARROW_VAR,
   parameter logic [7:0] WIDE_VAR   = OPC_WIDE_VAR,
   parameter logic [7:0] NARROW_IMM = OPC_NARROW_IMM,
   parameter logic [7:0] WIDE_IMM   = OPC_WIDE_IMM,
   parameter logic [2:0] IMM_SEL    = IMM_REG_SEL
) (
   input  logic [7:0] opcode,
   input  logic [2:0] reg_field,
   output op_decode_t dec
);

   always_comb begin
      dec.legal = 1'b0;
      dec.lane  = LANE_NARROW;
      dec.src   = CNT_FROM_OPERAND;
      case (opcode)
         NARROW_VAR: begin
            dec.legal = 1'b1;
         end
         WIDE_VAR: begin
            dec.legal = 1'b1;
            dec.lane  = LANE_WIDE;
         end
         NARROW_IMM: begin
            dec.legal = (reg_field == IMM_SEL);
            dec.src   = CNT_FROM_IMM;
         end
         WIDE_IMM: begin
            dec.legal = (reg_field == IMM_SEL);
            dec.lane  = LANE_WIDE;
            dec.src   = CNT_FROM_IMM;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/lsh_count_sel.sv
module lsh_count_sel
   import lsh_pkg::*;
#(
   parameter int CNT_W = 64,
   parameter int IMM_W = 8
) (
   input  cnt_src_e           src,
   input  logic [CNT_W-1:0]   count_op,
   input  logic [IMM_W-1:0]   count_imm,
   output logic [CNT_W-1:0]   count_eff
);

   if (IMM_W > CNT_W) begin : g_bad_imm_w
      $error("lsh_count_sel: IMM_W must not exceed CNT_W");
   end

   assign count_eff = (src == CNT_FROM_IMM) ? CNT_W'(count_imm) : count_op;

endmodule

// File: rtl/lsh_lane_array.sv
module lsh_lane_array #(
   parameter int DATA_W     = 64,
   parameter int LANE_W     = 32,
   parameter int CNT_W      = 64,
   parameter bit LOG_BARREL = 1'b1
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [CNT_W-1:0]  count,
   output logic [DATA_W-1:0] data_o
);

   localparam int LANES = DATA_W / LANE_W;
   localparam int SH_W  = $clog2(LANE_W);

   if (DATA_W % LANE_W != 0) begin : g_bad_split
      $error("lsh_lane_array: DATA_W must be a multiple of LANE_W");
   end
   if ((LANE_W & (LANE_W - 1)) != 0 || LANE_W < 2) begin : g_bad_lane
      $error("lsh_lane_array: LANE_W must be a power of two");
   end
   if (CNT_W <= SH_W) begin : g_bad_cnt
      $error("lsh_lane_array: CNT_W too narrow for LANE_W");
   end

   // Any amount at or above the lane width empties every lane
   logic oversize;
   assign oversize = (count >= CNT_W'(LANE_W));

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] slice;
      logic [LANE_W-1:0] shifted;

      assign slice = data_i[g*LANE_W +: LANE_W];

      if (LOG_BARREL) begin : g_log
         logic [LANE_W-1:0] stage [SH_W+1];
         assign stage[0] = slice;
         for (genvar s = 0; s < SH_W; s++) begin : g_stage
            assign stage[s+1] = count[s] ? (stage[s] << (1 << s)) : stage[s];
         end
         assign shifted = stage[SH_W];
      end else begin : g_flat
         assign shifted = slice << count[SH_W-1:0];
      end

      assign data_o[g*LANE_W +: LANE_W] = oversize ? '0 : shifted;
   end

endmodule

// File: rtl/packed_lsh.sv
module packed_lsh
   import lsh_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int NARROW_W   = 32,
   parameter int WIDE_W     = 64,
   parameter int CNT_W      = 64,
   parameter int IMM_W      = 8,
   parameter bit LOG_BARREL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_opcode,
   input  logic [2:0]        in_reg_field,
   input  logic [DATA_W-1:0] in_data,
   input  logic [CNT_W-1:0]  in_count,
   input  logic [IMM_W-1:0]  in_imm,
   output logic              out_valid,
   output logic              out_illegal,
   output logic [DATA_W-1:0] result
);

   if (NARROW_W >= WIDE_W) begin : g_bad_order
      $error("packed_lsh: NARROW_W must be smaller than WIDE_W");
   end
   if (WIDE_W > DATA_W) begin : g_bad_wide
      $error("packed_lsh: WIDE_W must not exceed DATA_W");
   end

   op_decode_t        dec;
   logic [CNT_W-1:0]  eff_count;
   logic [DATA_W-1:0] narrow_res;
   logic [DATA_W-1:0] wide_res;
   logic [DATA_W-1:0] next_res;
   logic              accept;

   lsh_decode u_decode (
      .opcode    (in_opcode),
      .reg_field (in_reg_field),
      .dec       (dec)
   );

   lsh_count_sel #(.CNT_W(CNT_W), .IMM_W(IMM_W)) u_count (
      .src       (dec.src),
      .count_op  (in_count),
      .count_imm (in_imm),
      .count_eff (eff_count)
   );

   lsh_lane_array #(
      .DATA_W(DATA_W), .LANE_W(NARROW_W), .CNT_W(CNT_W), .LOG_BARREL(LOG_BARREL)
   ) u_narrow (
      .data_i (in_data),
      .count  (eff_count),
      .data_o (narrow_res)
   );

   lsh_lane_array #(
      .DATA_W(DATA_W), .LANE_W(WIDE_W), .CNT_W(CNT_W), .LOG_BARREL(LOG_BARREL)
   ) u_wide (
      .data_i (in_data),
      .count  (eff_count),
      .data_o (wide_res)
   );

   assign next_res = (dec.lane == LANE_WIDE) ? wide_res : narrow_res;
   assign accept   = in_valid & dec.legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
         result      <= '0;
      end else begin
         out_valid   <= accept;
         out_illegal <= in_valid & ~dec.legal;
         if (accept) begin
            result <= next_res;
         end
      end
   end

   // R6: the two output flags never rise together
   a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_valid, out_illegal}));

   // R6: a rejected operation leaves the held result alone
   a_r6_illegal_holds: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> $stable(result));

   // R7: a flag is only raised for an operation presented one cycle earlier
   a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid || out_illegal) |-> $past(in_valid));

   // R8: an idle cycle produces no flag and no change
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_illegal && $stable(result)));

   // R4: oversize amounts clear the result for both lane sizes
   a_r4_wide_oversize: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dec.lane == LANE_WIDE && eff_count >= CNT_W'(WIDE_W))
      |=> (result == '0));

   a_r4_narrow_oversize: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dec.lane == LANE_NARROW && eff_count >= CNT_W'(NARROW_W))
      |=> (result == '0));

   // R5: a zero amount passes the operand through unchanged
   a_r5_zero_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && eff_count == '0) |=> (result == $past(in_data)));

endmodule

// File: tb/packed_lsh_test.sv
module packed_lsh_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_opcode = 8'h00;
   logic [2:0]  in_reg_field = 3'b000;
   logic [63:0] in_data = '0;
   logic [63:0] in_count = '0;
   logic [7:0]  in_imm = 8'h00;
   logic        out_valid;
   logic        out_illegal;
   logic [63:0] result;

   always #5 clk = ~clk;

   packed_lsh uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_opcode    (in_opcode),
      .in_reg_field (in_reg_field),
      .in_data      (in_data),
      .in_count     (in_count),
      .in_imm       (in_imm),
      .out_valid    (out_valid),
      .out_illegal  (out_illegal),
      .result       (result)
   );

   int          n_checks = 0;
   int          n_fail   = 0;
   bit          finished = 1'b0;

   // Pending expectation for the operation driven on the previous falling edge
   bit          pend = 1'b0;
   logic        exp_valid;
   logic        exp_ill;
   logic [63:0] exp_res;
   string       exp_tag;
   logic [63:0] last_res = '0;
   logic [63:0] lcg = 64'h1234_5678_9ABC_DEF1;

   function automatic logic [63:0] model(input logic [63:0] d, input bit wide,
                                         input logic [63:0] c);
      logic [31:0] lo;
      logic [31:0] hi;
      if (wide) begin
         if (c >= 64) return 64'd0;
         return d << c[5:0];
      end
      if (c >= 32) return 64'd0;
      lo = d[31:0];
      hi = d[63:32];
      lo = lo << c[4:0];
      hi = hi << c[4:0];
      return {hi, lo};
   endfunction

   task automatic check_pending();
      if (pend) begin
         n_checks++;
         if (out_valid !== exp_valid || out_illegal !== exp_ill || result !== exp_res) begin
            n_fail++;
            $display("FAIL %s: valid=%0b illegal=%0b result=%h, expected valid=%0b illegal=%0b result=%h",
                     exp_tag, out_valid, out_illegal, result, exp_valid, exp_ill, exp_res);
         end
      end
   endtask

   task automatic step(input logic v, input logic [7:0] op, input logic [2:0] rg,
                       input logic [63:0] d, input logic [63:0] c, input logic [7:0] im,
                       input string tag);
      bit legal;
      bit wide;
      logic [63:0] amt;
      @(negedge clk);
      check_pending();
      legal = 1'b0; wide = 1'b0; amt = c;
      if (op == 8'hF2) legal = 1'b1;
      else if (op == 8'hF3) begin legal = 1'b1; wide = 1'b1; end
      else if ((op == 8'h72 || op == 8'h73) && rg == 3'b110) begin
         legal = 1'b1; wide = (op == 8'h73); amt = {56'd0, im};
      end
      in_valid = v; in_opcode = op; in_reg_field = rg;
      in_data = d; in_count = c; in_imm = im;
      exp_valid = v && legal;
      exp_ill   = v && !legal;
      if (v && legal) last_res = model(d, wide, amt);
      exp_res = last_res;
      exp_tag = tag;
      pend    = 1'b1;
   endtask

   function automatic logic [63:0] next_rand();
      lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
      return lcg;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stimulus
      logic [63:0] pats [3];
      logic [63:0] bigs [6];
      pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
      pats[1] = 64'h8123_4567_89AB_CDEF;
      pats[2] = next_rand();
      bigs[0] = 64'h0000_0001_0000_0000;
      bigs[1] = 64'h8000_0000_0000_0000;
      bigs[2] = 64'h0000_0001_0000_0003;
      bigs[3] = 64'hFFFF_FFFF_FFFF_FFFF;
      bigs[4] = 64'h0000_0000_0000_0100;
      bigs[5] = 64'h0000_0000_0000_0041;

      // R9: reset state
      repeat (3) @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0 || out_illegal !== 1'b0 || result !== 64'd0) begin
         n_fail++;
         $display("FAIL R9: valid=%0b illegal=%0b result=%h, expected 0 0 0",
                  out_valid, out_illegal, result);
      end
      rst_n = 1'b1;

      // R1 R2 R5 R7: operand-count forms, every amount up to past the lane, back to back
      for (int p = 0; p < 3; p++) begin
         for (int c = 0; c <= 70; c++) begin
            step(1'b1, 8'hF2, 3'(c), pats[p], 64'(c), 8'(next_rand()), "R1 narrow operand count");
            step(1'b1, 8'hF3, 3'(c + 1), pats[p], 64'(c), 8'(next_rand()), "R2 wide operand count");
         end
      end

      // R4: full-width amounts, including high bits with small low bits
      for (int p = 0; p < 3; p++) begin
         for (int b = 0; b < 6; b++) begin
            step(1'b1, 8'hF2, 3'b000, pats[p], bigs[b], 8'h01, "R4 narrow oversize");
            step(1'b1, 8'hF3, 3'b000, pats[p], bigs[b], 8'h01, "R4 wide oversize");
         end
      end

      // R3: immediate forms, every immediate value, count operand carries noise
      for (int p = 0; p < 3; p++) begin
         for (int i = 0; i < 256; i++) begin
            step(1'b1, 8'h72, 3'b110, pats[p], next_rand(), 8'(i), "R3 narrow immediate");
            step(1'b1, 8'h73, 3'b110, pats[p], next_rand(), 8'(i), "R3 wide immediate");
         end
      end

      // R6: immediate opcodes with wrong selector field
      for (int r = 0; r < 8; r++) begin
         if (r == 6) continue;
         step(1'b1, 8'h72, 3'(r), next_rand(), 64'd1, 8'd1, "R6 bad selector narrow");
         step(1'b1, 8'h73, 3'(r), next_rand(), 64'd1, 8'd1, "R6 bad selector wide");
      end

      // R6: every other opcode value, interleaved with legal ones
      for (int o = 0; o < 256; o++) begin
         if (o == 'hF2 || o == 'hF3 || o == 'h72 || o == 'h73) continue;
         step(1'b1, 8'(o), 3'b110, next_rand(), 64'd4, 8'd4, "R6 unknown opcode");
         if (o % 32 == 0)
            step(1'b1, 8'hF3, 3'b000, next_rand(), 64'd7, 8'd0, "R7 legal between illegal");
      end

      // R8: idle cycles with changing inputs
      step(1'b1, 8'hF2, 3'b000, 64'h0123_4567_89AB_CDEF, 64'd4, 8'd0, "R1 before idle");
      for (int k = 0; k < 8; k++)
         step(1'b0, 8'hF3, 3'b000, next_rand(), 64'd1, 8'd1, "R8 idle");

      // Flush the last pending check
      @(negedge clk);
      check_pending();
      pend = 1'b0;

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule